// File: doc/BRIEF.md
# Transmit Outcome Status and Collision Counter

This block watches the outcome of every transmit attempt made by a 10 Mb/s Ethernet MAC. It keeps a sticky status register and a count of consecutive collisions. The MAC sends it one-cycle pulses: attempt started, attempt finished cleanly, attempt cut short by a collision, and carrier dropped during sending. It also sends a bit-time tick, which the block uses to time each attempt for jabber. Five sticky status bits record carrier loss, collision, a sixteenth consecutive collision, jabber, and transmit done. Four of these bits can raise the single level interrupt through their own enable bits. Carrier loss is reported as status only.

Software reaches the block through a plain register port. A write is applied at the clock edge when `wr_en` is high. Reads are combinational from `rd_addr`. Status bits are cleared by writing a one to them. The port has no data stream, so there is no valid/ready handshake and no back-pressure. The MAC pulses must be acted on in the cycle they arrive, and the block always accepts them.

Top module: `txs_err_status`

## Requirements
- R1: After reset, the status register (address 0), the enable register (address 1) and the collision count (address 2) all read 0x00, and `irq` is low.
- R2: A `carr_lost` pulse sets status bit 0. Bit 0 has no enable: enable bit 0 always reads 0, and a status of 0x01 alone never raises `irq`.
- R3: A `tx_coll` pulse sets status bit 1 and raises the 4-bit collision count (address 2, bits 3:0; bits 7:4 read 0) by one. `tx_coll` takes priority over a `tx_ok` pulse in the same cycle.
- R4: A collision that arrives while the count is 15 wraps the count to 0. It also sets status bit 2 (sixteen collisions) and status bit 7 (transmit done).
- R5: A `tx_ok` pulse sets status bit 7 and returns the collision count to 0.
- R6: Suppose `bit_tick` is seen JAB_BITS times after `tx_start`, and no `tx_coll` or `tx_ok` arrives in between. Then the block sets status bit 3 (jabber) and bit 7, clears the collision count and ends the timed attempt. An attempt that ends sooner never sets bit 3.
- R7: Writing address 0 clears each status bit written as 1 and leaves each bit written as 0 unchanged. A set event in the same cycle as a clear wins.
- R8: Address 1 holds the enables for status bits 1, 2, 3 and 7. The other enable bits read 0. `irq` is high exactly when some status bit is set and also enabled.
- R9: Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Pulse: a transmit attempt begins |
| bit_tick | input | 1 | One pulse per transmitted bit time |
| tx_ok | input | 1 | Pulse: the attempt completed without error |
| tx_coll | input | 1 | Pulse: a collision ended the attempt |
| carr_lost | input | 1 | Pulse: carrier dropped while sending |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| coll_cnt | output | 4 | Current consecutive-collision count |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives sixteen back-to-back collisions. A counter that saturated at 15 would keep reading 15 at that point, and one that missed the wrap would never raise the sixteen-collision and done bits. The bench stops the jabber timer one tick short of its limit and then gives the final tick, so an off-by-one threshold shows up as jabber set too early or too late. It also ends an attempt before the limit and keeps ticking, which catches a timer that is not stopped. It writes zeros to status, and it clears the collision bit in the same cycle a new collision arrives, which catches a plain write-to-clear and a wrong clear-versus-set priority. It also confirms that carrier loss alone, and fully masked status, leave the interrupt low.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_CARR = 0;
  localparam int unsigned B_COLL = 1;
  localparam int unsigned B_C16  = 2;
  localparam int unsigned B_JAB  = 3;
  localparam int unsigned B_DONE = 7;
  localparam logic [REG_W-1:0] IEN_MASK = 8'h8E;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_IEN  = 2'd1,
    A_CCNT = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/txs_jabber_timer.sv
module txs_jabber_timer #(
  parameter int unsigned JAB_BITS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_start,
  input  logic bit_tick,
  input  logic att_end,
  output logic jab_hit
);
  localparam int unsigned TW = $clog2(JAB_BITS + 1);
  localparam logic [TW-1:0] LAST = TW'(JAB_BITS - 1);

  logic          active_q;
  logic [TW-1:0] ticks_q;

  assign jab_hit = active_q && bit_tick && (ticks_q == LAST) && !att_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ticks_q  <= '0;
    end else if (tx_start) begin
      active_q <= 1'b1;
      ticks_q  <= '0;
    end else if (att_end || jab_hit) begin
      active_q <= 1'b0;
      ticks_q  <= '0;
    end else if (active_q && bit_tick) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end
endmodule

// File: rtl/txs_coll_counter.sv
module txs_coll_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coll,
  input  logic             clr,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap = coll && (cnt_q == TOP);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (coll) cnt_q <= cnt_q + 1'b1;
    else if (clr)  cnt_q <= '0;
  end
endmodule

// File: rtl/txs_status_regs.sv
module txs_status_regs
  import txs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] ien
);
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] ien_q;

  assign clr_vec = (wr_en && wr_addr == A_STAT) ? wr_data : '0;

  for (genvar g = 0; g < REG_W; g++) begin : g_stat
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_vec[g]) bit_q <= 1'b1;
      else if (clr_vec[g]) bit_q <= 1'b0;
    end
    assign status[g] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ien_q <= '0;
    else if (wr_en && wr_addr == A_IEN) ien_q <= wr_data & IEN_MASK;
  end
  assign ien = ien_q;
endmodule

// File: rtl/txs_err_status.sv
module txs_err_status
  import txs_pkg::*;
#(
  parameter int unsigned JAB_BITS = 20000,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic             bit_tick,
  input  logic             tx_ok,
  input  logic             tx_coll,
  input  logic             carr_lost,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] coll_cnt,
  output logic             irq
);
  logic             jab_hit;
  logic             wrap;
  logic             ok_eff;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] ien_q;
  logic [CNT_W-1:0] cnt_q;

  assign ok_eff = tx_ok && !tx_coll;

  txs_jabber_timer #(.JAB_BITS(JAB_BITS)) u_jab (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .bit_tick(bit_tick),
    .att_end(tx_coll || tx_ok), .jab_hit(jab_hit)
  );

  txs_coll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .coll(tx_coll), .clr(ok_eff || jab_hit),
    .wrap(wrap), .cnt(cnt_q)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_CARR] = carr_lost;
    set_vec[B_COLL] = tx_coll;
    set_vec[B_C16]  = wrap;
    set_vec[B_JAB]  = jab_hit;
    set_vec[B_DONE] = ok_eff || wrap || jab_hit;
  end

  txs_status_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(status_q), .ien(ien_q)
  );

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = status_q;
      A_IEN:   rd_data = ien_q;
      A_CCNT:  rd_data = 8'(cnt_q);
      default: rd_data = '0;
    endcase
  end

  assign coll_cnt = cnt_q;
  assign irq      = |(status_q & ien_q);
endmodule

// File: rtl/txs_err_status_chk.sv
module txs_err_status_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_ok,
  input logic             tx_coll,
  input logic             carr_lost,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic [7:0]       status_q,
  input logic [7:0]       ien_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_COLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_coll && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1) && status_q[1]); // R3
  AST_COLL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_coll && cnt_q == TOP) |=> (cnt_q == '0) && status_q[2] && status_q[7]); // R4
  AST_OK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && !tx_coll) |=> (cnt_q == '0) && status_q[7]); // R5
  AST_CARR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    carr_lost |=> status_q[0]); // R2
  AST_CARR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h01) |-> !irq); // R2
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data == 8'h00) |=> ((status_q & $past(status_q)) == $past(status_q))); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 8'h00) |-> !irq); // R8
  AST_IEN_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q[0]); // R2
endmodule

bind txs_err_status txs_err_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ok(tx_ok), .tx_coll(tx_coll),
  .carr_lost(carr_lost), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .status_q(status_q), .ien_q(ien_q), .cnt_q(cnt_q), .irq(irq)
);

// File: tb/txs_err_status_tb.sv
module txs_err_status_tb_top;
  localparam int unsigned JB = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start = 1'b0, bit_tick = 1'b0, tx_ok = 1'b0, tx_coll = 1'b0, carr_lost = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] coll_cnt;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] addr;
    logic [7:0] exp;
    bit         exp_irq;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  txs_err_status #(.JAB_BITS(JB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .bit_tick(bit_tick),
    .tx_ok(tx_ok), .tx_coll(tx_coll), .carr_lost(carr_lost), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .coll_cnt(coll_cnt), .irq(irq)
  );

  // Monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd_data !== it.exp || irq !== it.exp_irq) begin
          fails++;
          $display("FAIL %s: addr %0d data %02h irq %0b, expected data %02h irq %0b",
                   it.tag, it.addr, rd_data, irq, it.exp, it.exp_irq);
        end
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input bit ei, input string tag);
    item_t it;
    @(posedge clk); #1;
    rd_addr = a;
    it.addr = a; it.exp = e; it.exp_irq = ei; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tx_start  = 1'b1;
      1: tx_coll   = 1'b1;
      2: tx_ok     = 1'b1;
      default: carr_lost = 1'b1;
    endcase
    @(negedge clk);
    tx_start = 1'b0; tx_coll = 1'b0; tx_ok = 1'b0; carr_lost = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(2'd0, 8'h00, 1'b0, "R1 status");
    expect_rd(2'd1, 8'h00, 1'b0, "R1 enable");
    expect_rd(2'd2, 8'h00, 1'b0, "R1 count");
    // R2 carrier loss, no enable
    pulse(3);
    wr(2'd1, 8'hFF);
    expect_rd(2'd1, 8'h8E, 1'b0, "R8 enable mask");
    expect_rd(2'd0, 8'h01, 1'b0, "R2 carrier bit, no irq");
    wr(2'd0, 8'h01);
    expect_rd(2'd0, 8'h00, 1'b0, "R7 clear carrier");
    // R3 collision
    pulse(0); pulse(1);
    expect_rd(2'd0, 8'h02, 1'b1, "R3 collision bit");
    expect_rd(2'd2, 8'h01, 1'b1, "R3 count one");
    wr(2'd0, 8'h00);
    expect_rd(2'd0, 8'h02, 1'b1, "R7 zero write keeps");
    wr(2'd0, 8'h02);
    expect_rd(2'd0, 8'h00, 1'b0, "R7 one write clears");
    // R4 wrap at sixteenth
    for (int i = 0; i < 14; i++) begin pulse(0); pulse(1); end
    expect_rd(2'd2, 8'h0F, 1'b1, "R3 count fifteen");
    pulse(0); pulse(1);
    expect_rd(2'd2, 8'h00, 1'b1, "R4 count wraps");
    expect_rd(2'd0, 8'h86, 1'b1, "R4 sixteen and done");
    wr(2'd0, 8'hFF);
    // R5 success clears count
    pulse(0); pulse(1); pulse(0); pulse(2);
    expect_rd(2'd2, 8'h00, 1'b1, "R5 count cleared");
    expect_rd(2'd0, 8'h82, 1'b1, "R5 done bit");
    wr(2'd0, 8'hFF);
    // R6 jabber threshold
    pulse(0); pulse(1); pulse(0);
    ticks(JB - 1);
    expect_rd(2'd0, 8'h02, 1'b1, "R6 no jabber one tick short");
    ticks(1);
    expect_rd(2'd0, 8'h8A, 1'b1, "R6 jabber and done");
    expect_rd(2'd2, 8'h00, 1'b1, "R6 count cleared");
    wr(2'd0, 8'hFF);
    // R6 early end stops timer
    pulse(0);
    ticks(30);
    pulse(2);
    ticks(40);
    expect_rd(2'd0, 8'h80, 1'b1, "R6 ended attempt no jabber");
    wr(2'd0, 8'hFF);
    // R7 set wins over clear
    pulse(0); pulse(1);
    @(negedge clk);
    tx_coll = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h02;
    @(negedge clk);
    tx_coll = 1'b0; wr_en = 1'b0;
    expect_rd(2'd0, 8'h02, 1'b1, "R7 set wins");
    expect_rd(2'd2, 8'h02, 1'b1, "R3 count two");
    // R8 masking
    wr(2'd1, 8'h00);
    expect_rd(2'd0, 8'h02, 1'b0, "R8 masked");
    pulse(2);
    wr(2'd1, 8'h80);
    expect_rd(2'd0, 8'h82, 1'b1, "R8 done enable only");
    wr(2'd0, 8'h80);
    expect_rd(2'd0, 8'h02, 1'b0, "R8 collision not enabled");
    // R9 reserved address
    expect_rd(2'd3, 8'h00, 1'b0, "R9 reserved reads zero");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule